// File: doc/BRIEF.md
# Tagged Receive Pipeline with Run-Length Expansion

This block sits between a receive FIFO and the CPU. The FIFO holds 9-bit entries: 8 data bits and a tag bit. There is also a side flag that marks a tagged entry as a run-length count. The block keeps two holding stages full. Stage 1 is loaded from the FIFO head, and stage 2 is loaded from stage 1. Stage 2 is the one a downstream reader normally drains. Each stage empties when its read strobe is pulsed.

A tagged entry is not a run-length count when run-length expansion is disabled, or when its count flag is clear. Such an entry travels through the stages like data. It raises a level interrupt for as long as it sits in either stage, and the CPU must clear it with a read.

When expansion is enabled, a tagged count entry is not staged. It loads a run counter, and the next data byte that reaches stage 1 is replicated into stage 2. A count of N yields N+1 copies of that byte. A count that is still pending survives until the next data byte arrives, unless a newer count replaces it. The FIFO pop is a same-cycle strobe for a first-word-fall-through FIFO.

Top module: `rx_tag_pipe`

## Requirements
- R1: After reset both stages are empty, both tag bits are clear, no count is pending, the interrupt is low, and with an empty FIFO no pop is issued.
- R2: When stage 1 is empty and the FIFO is not empty, the head entry is popped into stage 1 on the next edge. When stage 2 is empty, stage 1 moves into it on the same edge as a pop. Two bytes pushed into an idle block therefore occupy stage 2 (first byte) and stage 1 (second byte) two cycles later.
- R3: While the FIFO is empty and no expansion copy is due, stage 1 neither advances nor changes, even when stage 2 is empty.
- R4: A read strobe empties its stage and clears its tag on the next edge. If the FIFO holds data, a freed stage is refilled on that same edge.
- R5: `irq` is high in exactly those cycles in which a full stage holds a set tag. The status bits are: bit 0 = stage 1 tagged, bit 1 = stage 2 tagged, bit 2 = stage 1 full, bit 3 = stage 2 full, bit 4 = run count pending (non-zero).
- R6: A tagged byte in stage 2 stays there, unchanged and with `irq` high, until stage 2 is read.
- R7: With `rle_en` high, a popped entry with both tag and count flag set loads the run counter with its data bits, and stage 1 stays empty.
- R8: With `rle_en` high and a non-zero count, an untagged byte in stage 1 is held there. One copy per cycle goes into a free stage 2, and the counter decrements on each copy. At zero the byte advances normally, so a count of N produces N+1 copies.
- R9: With `rle_en` low, an entry with the count flag set is staged as an ordinary tagged byte and raises the interrupt.
- R10: A tagged entry whose count flag is clear is staged as a tagged byte even while a count is pending. The pending count is kept and applied to the next untagged byte.
- R11: A count entry that arrives while a count is already pending replaces it.
- R12: `fifo_pop` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rle_en | input | 1 | Enables run-length count recognition and expansion |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_data | input | DATA_W | Data bits of the FIFO head |
| fifo_tag | input | 1 | Tag bit of the FIFO head |
| fifo_rlc | input | 1 | Head is a run-length count (meaningful when tagged) |
| fifo_pop | output | 1 | Consume the FIFO head at this edge |
| rd_s1 | input | 1 | Read strobe that empties stage 1 |
| rd_s2 | input | 1 | Read strobe that empties stage 2 |
| s1_data | output | DATA_W | Stage 1 data |
| s1_tag | output | 1 | Stage 1 tag |
| s1_full | output | 1 | Stage 1 holds an entry |
| s2_data | output | DATA_W | Stage 2 data |
| s2_tag | output | 1 | Stage 2 tag |
| s2_full | output | 1 | Stage 2 holds an entry |
| status | output | 5 | Pipeline status, bit layout in R5 |
| irq | output | 1 | Level interrupt for tagged bytes held in a stage |

## Verification
The bench runs several input patterns.

- **Plain fill and drain with the FIFO running dry.** This separates stalling on an empty FIFO from advancing into a free stage 2.
- **A tagged address left unread.** This shows that the interrupt and the stall track the tag.
- **A count followed by data.** This separates held replication from normal shifting, and checks for N+1 copies.
- **A count with expansion disabled.** This shows the count being staged as a tagged byte instead.
- **A count, then a tagged address, then data.** This shows that a pending count skips tagged bytes.
- **Two counts back to back.** This shows that the second count replaces the first.

A behavioural model is compared against every output after every clock.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  // What stage 2 does this cycle
  typedef enum logic [1:0] {
    S2_KEEP  = 2'd0,
    S2_COPY  = 2'd1,   // replica of stage 1, stage 1 held
    S2_SHIFT = 2'd2    // stage 1 moves forward
  } s2_act_e;

  // What happens to the FIFO head this cycle
  typedef enum logic [1:0] {
    S1_KEEP  = 2'd0,
    S1_TAKE  = 2'd1,   // head loads stage 1
    S1_COUNT = 2'd2    // head loads the run counter
  } s1_act_e;

  localparam int STAT_W      = 5;
  localparam int ST_S1_TAG   = 0;
  localparam int ST_S2_TAG   = 1;
  localparam int ST_S1_FULL  = 2;
  localparam int ST_S2_FULL  = 3;
  localparam int ST_PENDING  = 4;

endpackage

// File: rtl/rxp_hold_reg.sv
module rxp_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clr,
  input  logic [DATA_W-1:0] din,
  input  logic              tin,
  output logic [DATA_W-1:0] data,
  output logic              tag,
  output logic              full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      tag  <= 1'b0;
      full <= 1'b0;
    end else if (load) begin
      data <= din;
      tag  <= tin;
      full <= 1'b1;
    end else if (clr) begin
      tag  <= 1'b0;
      full <= 1'b0;
    end
  end

  // R4: a clear with no refill leaves the stage empty and untagged
  a_r4_clr_empties: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> (!full && !tag));

  // R4: a load always leaves the stage full with the offered byte
  a_r4_load_fills: assert property (@(posedge clk) disable iff (rst)
    load |=> (full && data == $past(din) && tag == $past(tin)));

endmodule

// File: rtl/rxp_run_ctr.sv
module rxp_run_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             nz
);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= ld_val;
    else if (dec && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign nz = (cnt != '0);

  // R8: each copy takes exactly one off the count
  a_r8_dec_by_one: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> (cnt == $past(cnt) - 1'b1));

  // R11: a new count replaces whatever was pending
  a_r11_overwrite: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(ld_val)));

  // R10: a pending count is kept while nothing loads or consumes it
  a_r10_keep_pending: assert property (@(posedge clk) disable iff (rst)
    (!load && !dec) |=> $stable(cnt));

endmodule

// File: rtl/rxp_seq.sv
module rxp_seq
  import rxp_pkg::*;
(
  input  logic    s1_full,
  input  logic    s1_tag,
  input  logic    s2_full,
  input  logic    rd_s1,
  input  logic    rd_s2,
  input  logic    rle_en,
  input  logic    run_nz,
  input  logic    fifo_empty,
  input  logic    head_tag,
  input  logic    head_rlc,
  output s2_act_e s2_act,
  output s1_act_e s1_act,
  output logic    pop
);

  logic occ1, occ2, expand, free1, head_is_cnt;

  always_comb begin
    // occupancy after this cycle's reads
    occ1        = s1_full && !rd_s1;
    occ2        = s2_full && !rd_s2;
    expand      = occ1 && !s1_tag && rle_en && run_nz;
    head_is_cnt = rle_en && head_tag && head_rlc;

    s2_act = S2_KEEP;
    if (occ1 && !occ2) begin
      if (expand)
        s2_act = S2_COPY;
      else if (!fifo_empty)
        s2_act = S2_SHIFT;
    end

    free1  = !occ1 || (s2_act == S2_SHIFT);
    s1_act = S1_KEEP;
    pop    = 1'b0;
    if (free1 && !fifo_empty) begin
      pop    = 1'b1;
      s1_act = head_is_cnt ? S1_COUNT : S1_TAKE;
    end
  end

endmodule

// File: rtl/rx_tag_pipe.sv
module rx_tag_pipe
  import rxp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rle_en,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_tag,
  input  logic              fifo_rlc,
  output logic              fifo_pop,
  input  logic              rd_s1,
  input  logic              rd_s2,
  output logic [DATA_W-1:0] s1_data,
  output logic              s1_tag,
  output logic              s1_full,
  output logic [DATA_W-1:0] s2_data,
  output logic              s2_tag,
  output logic              s2_full,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  localparam int CNT_W    = DATA_W;
  localparam int N_STAGES = 2;

  s2_act_e s2_act;
  s1_act_e s1_act;
  logic    run_nz;
  logic [CNT_W-1:0] run_cnt;

  logic [DATA_W-1:0] st_din  [N_STAGES];
  logic              st_tin  [N_STAGES];
  logic              st_ld   [N_STAGES];
  logic              st_clr  [N_STAGES];
  logic [DATA_W-1:0] st_data [N_STAGES];
  logic              st_tag  [N_STAGES];
  logic              st_full [N_STAGES];

  rxp_seq u_seq (
    .s1_full    (s1_full),
    .s1_tag     (s1_tag),
    .s2_full    (s2_full),
    .rd_s1      (rd_s1),
    .rd_s2      (rd_s2),
    .rle_en     (rle_en),
    .run_nz     (run_nz),
    .fifo_empty (fifo_empty),
    .head_tag   (fifo_tag),
    .head_rlc   (fifo_rlc),
    .s2_act     (s2_act),
    .s1_act     (s1_act),
    .pop        (fifo_pop)
  );

  rxp_run_ctr #(.CNT_W(CNT_W)) u_run (
    .clk    (clk),
    .rst    (rst),
    .load   (s1_act == S1_COUNT),
    .ld_val (fifo_data),
    .dec    (s2_act == S2_COPY),
    .cnt    (run_cnt),
    .nz     (run_nz)
  );

  // stage 0 = stage 1 (fed by FIFO), stage 1 = stage 2 (fed by stage 1)
  always_comb begin
    st_din[0] = fifo_data;
    st_tin[0] = fifo_tag;
    st_ld[0]  = (s1_act == S1_TAKE);
    st_clr[0] = rd_s1 || (s2_act == S2_SHIFT);
    st_din[1] = st_data[0];
    st_tin[1] = st_tag[0];
    st_ld[1]  = (s2_act != S2_KEEP);
    st_clr[1] = rd_s2;
  end

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    rxp_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (st_ld[g]),
      .clr  (st_clr[g]),
      .din  (st_din[g]),
      .tin  (st_tin[g]),
      .data (st_data[g]),
      .tag  (st_tag[g]),
      .full (st_full[g])
    );
  end

  assign s1_data = st_data[0];
  assign s1_tag  = st_tag[0];
  assign s1_full = st_full[0];
  assign s2_data = st_data[1];
  assign s2_tag  = st_tag[1];
  assign s2_full = st_full[1];

  // interrupt registered from the next-state tag view
  logic nxt_t1, nxt_t2;
  always_comb begin
    nxt_t1 = st_ld[0] ? st_tin[0] : (st_clr[0] ? 1'b0 : s1_tag);
    nxt_t2 = st_ld[1] ? st_tin[1] : (st_clr[1] ? 1'b0 : s2_tag);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= nxt_t1 || nxt_t2;
  end

  always_comb begin
    status             = '0;
    status[ST_S1_TAG]  = s1_tag;
    status[ST_S2_TAG]  = s2_tag;
    status[ST_S1_FULL] = s1_full;
    status[ST_S2_FULL] = s2_full;
    status[ST_PENDING] = run_nz;
  end

  // R12: never consume from an empty FIFO
  a_r12_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  // R5: interrupt tracks tagged stages
  a_r5_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == ((s1_full && s1_tag) || (s2_full && s2_tag)));

  // R6: an unread tagged byte in stage 2 stays put
  a_r6_tag_stall: assert property (@(posedge clk) disable iff (rst)
    (s2_full && s2_tag && !rd_s2) |=> (s2_full && s2_tag && $stable(s2_data)));

  // R3: no advance of stage 1 with an empty FIFO unless a copy is due
  a_r3_no_advance: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && !rd_s1 && !(rle_en && run_nz && s1_full && !s1_tag))
      |=> (s1_full == $past(s1_full) && (!s1_full || $stable(s1_data))));

  // R8: expansion holds stage 1 and copies it into stage 2
  a_r8_hold_copy: assert property (@(posedge clk) disable iff (rst)
    (rle_en && run_nz && s1_full && !s1_tag && !rd_s1 && (!s2_full || rd_s2))
      |=> (s1_full && $stable(s1_data) && s2_full && s2_data == $past(s1_data)));

  // R7: a recognised count never lands in stage 1
  a_r7_count_not_staged: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop && rle_en && fifo_tag && fifo_rlc) |=> !s1_full);

endmodule

// File: tb/rx_tag_pipe_tb.sv
module rx_tag_pipe_tb;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          rle_en = 1'b0;
  logic          fifo_empty = 1'b1;
  logic [DW-1:0] fifo_data = '0;
  logic          fifo_tag = 1'b0;
  logic          fifo_rlc = 1'b0;
  logic          fifo_pop;
  logic          rd_s1 = 1'b0;
  logic          rd_s2 = 1'b0;
  logic [DW-1:0] s1_data, s2_data;
  logic          s1_tag, s1_full, s2_tag, s2_full, irq;
  logic [4:0]    status;

  rx_tag_pipe #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .rle_en(rle_en), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_tag(fifo_tag), .fifo_rlc(fifo_rlc),
    .fifo_pop(fifo_pop), .rd_s1(rd_s1), .rd_s2(rd_s2),
    .s1_data(s1_data), .s1_tag(s1_tag), .s1_full(s1_full),
    .s2_data(s2_data), .s2_tag(s2_tag), .s2_full(s2_full),
    .status(status), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit auto_rd = 1'b0;

  // FIFO entries: {rlc, tag, data}
  logic [9:0] q[$];
  logic [8:0] rlog[$];   // {tag, data} of every stage-2 read

  // reference model state
  bit        m1f, m1t, m2f, m2t;
  logic [7:0] m1d, m2d;
  int        mcnt;

  task automatic chk(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_head();
    fifo_empty = (q.size() == 0);
    if (q.size() != 0) begin
      fifo_data = q[0][7:0];
      fifo_tag  = q[0][8];
      fifo_rlc  = q[0][9];
    end else begin
      fifo_data = '0; fifo_tag = 1'b0; fifo_rlc = 1'b0;
    end
  endtask

  task automatic push(bit rlc, bit tag, logic [7:0] d);
    q.push_back({rlc, tag, d});
    set_head();
  endtask

  task automatic compare_all();
    chk("R2 stage1", {m1f, m1t, m1d} == {s1_full, s1_tag, s1_data},
        {s1_full, s1_tag, s1_data}, {m1f, m1t, m1d});
    chk("R2 stage2", {m2f, m2t, m2d} == {s2_full, s2_tag, s2_data},
        {s2_full, s2_tag, s2_data}, {m2f, m2t, m2d});
    chk("R5 irq", irq == ((m1f && m1t) || (m2f && m2t)), irq, (m1f && m1t) || (m2f && m2t));
    chk("R5 status", status == {mcnt != 0, m2f, m1f, m2t, m1t}, status,
        {mcnt != 0, m2f, m1f, m2t, m1t});
  endtask

  task automatic step(bit r1, bit r2);
    bit f1, f2, exp_e, copy, shift, free1, epop, iscnt, empty;
    bit n1f, n1t, n2f, n2t;
    logic [7:0] n1d, n2d;
    int ncnt;
    rd_s1 = r1;
    rd_s2 = r2 | (auto_rd & m2f);
    set_head();
    #2;
    empty = (q.size() == 0);
    f1 = m1f && !rd_s1;
    f2 = m2f && !rd_s2;
    exp_e = f1 && !m1t && rle_en && (mcnt != 0);
    copy  = f1 && !f2 && exp_e;
    shift = f1 && !f2 && !exp_e && !empty;
    free1 = !f1 || shift;
    epop  = free1 && !empty;
    iscnt = epop && rle_en && q[0][8] && q[0][9];
    chk("R12 pop", fifo_pop == epop, fifo_pop, epop);
    if (rd_s2 && m2f) rlog.push_back({m2t, m2d});
    n1f = f1; n1t = f1 ? m1t : 1'b0; n1d = m1d;
    n2f = f2; n2t = f2 ? m2t : 1'b0; n2d = m2d;
    ncnt = mcnt;
    if (copy || shift) begin n2f = 1; n2t = m1t; n2d = m1d; end
    if (copy) ncnt = mcnt - 1;
    if (shift) begin n1f = 0; n1t = 0; end
    if (epop && iscnt) ncnt = q[0][7:0];
    else if (epop) begin n1f = 1; n1t = q[0][8]; n1d = q[0][7:0]; end
    @(posedge clk);
    #1;
    if (epop) void'(q.pop_front());
    m1f = n1f; m1t = n1t; m1d = n1d;
    m2f = n2f; m2t = n2t; m2d = n2d; mcnt = ncnt;
    rd_s1 = 1'b0; rd_s2 = 1'b0;
    set_head();
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic log_is(string req, int idx, bit t, logic [7:0] d);
    if (idx < rlog.size())
      chk(req, rlog[idx] == {t, d}, rlog[idx], {t, d});
    else
      chk(req, 1'b0, 32'hffff_ffff, {t, d});
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    m1f = 0; m1t = 0; m2f = 0; m2t = 0; m1d = '0; m2d = '0; mcnt = 0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    #2;
    // R1: reset state
    chk("R1 reset outputs", {s1_full, s2_full, s1_tag, s2_tag, irq, status} == '0,
        {s1_full, s2_full, s1_tag, s2_tag, irq, status}, 0);
    chk("R1 no pop when idle", fifo_pop == 1'b0, fifo_pop, 0);

    // R2: two bytes fill both stages
    push(0, 0, 8'h3C); push(0, 0, 8'hC3);
    step(0, 0);
    chk("R2 first byte in stage1", s1_full && !s2_full && s1_data == 8'h3C, s1_data, 8'h3C);
    step(0, 0);
    chk("R2 order in stages", s2_data == 8'h3C && s1_data == 8'hC3 && s2_full && s1_full,
        {s2_data, s1_data}, 16'h3CC3);
    // R3: empty FIFO, nothing moves
    run(3);
    chk("R3 stalls while empty", s2_data == 8'h3C && s1_data == 8'hC3, {s2_data, s1_data}, 16'h3CC3);
    step(0, 1);
    chk("R3 no move into freed stage2", !s2_full && s1_full && s1_data == 8'hC3,
        {s2_full, s1_full}, 2'b01);
    // R4: refill after read
    push(0, 0, 8'h5E);
    step(0, 0);
    chk("R4 refill", s2_data == 8'hC3 && s1_data == 8'h5E && s2_full && s1_full,
        {s2_data, s1_data}, 16'hC35E);
    step(1, 1);
    chk("R4 reads empty both", !s1_full && !s2_full, {s1_full, s2_full}, 0);

    // R5/R6: tagged address
    push(0, 1, 8'hA1); push(0, 0, 8'h10);
    step(0, 0);
    chk("R5 irq on stage1 tag", irq && status[0], {irq, status}, 6'b1_00101);
    step(0, 0);
    chk("R5 status stage2 tag", irq && status[1] && !status[0], status, 5'b01110);
    run(4);
    chk("R6 tagged stall", s2_full && s2_tag && s2_data == 8'hA1 && irq, s2_data, 8'hA1);
    step(0, 1);
    chk("R5 irq drops after read", !irq && !s2_full && s1_full, irq, 0);
    step(1, 0);

    // R7/R8: run-length expansion
    rle_en = 1'b1; auto_rd = 1'b1; rlog.delete();
    push(1, 1, 8'd3); push(0, 0, 8'h5A); push(0, 0, 8'h6B); push(0, 0, 8'h7C);
    step(0, 0);
    chk("R7 count pending, stage1 empty", status[4] && !s1_full, status, 5'b10000);
    run(20);
    chk("R8 copy total", rlog.size() == 5, rlog.size(), 5);
    for (int i = 0; i < 4; i++) log_is("R8 replica", i, 1'b0, 8'h5A);
    log_is("R8 release", 4, 1'b0, 8'h6B);
    chk("R8 counter back to zero", !status[4], status[4], 0);
    step(1, 0);

    // R9: counts staged when expansion disabled
    rle_en = 1'b0; auto_rd = 1'b0;
    push(1, 1, 8'h03); push(0, 0, 8'h77);
    step(0, 0);
    chk("R9 count staged tagged", s1_full && s1_tag && s1_data == 8'h03 && irq && !status[4],
        {s1_tag, s1_data}, 9'h103);
    step(1, 0);
    step(1, 0);
    run(1);

    // R10: tagged address skips the pending count
    rle_en = 1'b1; auto_rd = 1'b1; rlog.delete();
    push(1, 1, 8'd2); push(0, 1, 8'hA5); push(0, 0, 8'h11); push(0, 0, 8'h22); push(0, 0, 8'h33);
    run(25);
    chk("R10 read count", rlog.size() == 5, rlog.size(), 5);
    log_is("R10 address once", 0, 1'b1, 8'hA5);
    for (int i = 1; i < 4; i++) log_is("R10 data expanded", i, 1'b0, 8'h11);
    log_is("R10 next data", 4, 1'b0, 8'h22);
    step(1, 0);

    // R11: second count overwrites first
    rlog.delete();
    push(1, 1, 8'd5); push(1, 1, 8'd1); push(0, 0, 8'h44); push(0, 0, 8'h55); push(0, 0, 8'h66);
    run(20);
    chk("R11 read count", rlog.size() == 3, rlog.size(), 3);
    log_is("R11 copy a", 0, 1'b0, 8'h44);
    log_is("R11 copy b", 1, 1'b0, 8'h44);
    log_is("R11 next", 2, 1'b0, 8'h55);
    step(1, 0);
    run(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule